// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is a 16-bit timer with a small bank of channels, each of which either compares or captures. Each channel holds two values: a register that software writes through a simple write port, and a shadow latch that is the only value the comparator ever sees. A two-bit load-mode field per channel picks when a freshly written value moves from the register into the shadow latch. The choices are at once, when the counter is at zero, or when the counter meets the value already in the shadow latch. Because the value moves at a chosen moment, software can retune a period or a duty cycle in mid-run without producing a clipped or doubled pulse.

The counter runs in one of two modes. In up mode it rises from zero to the channel 0 shadow value and wraps. In up/down mode it rises to that value and falls back to zero. Channel 0 therefore sets the period. Every other channel in compare mode drives a reset/set PWM output: the output is set when the counter meets the period and cleared when it meets the channel's own shadow value. In capture mode, a selected edge on a channel's input records the counter value in the channel register. That value then travels to the shadow latch under the same load-mode rules, which frees the register for the next event.

Top module: `dbuf_timer`

## Requirements
- R1: While `rst` is high, on each clock edge the counter, every channel register, every shadow latch and every PWM output are set to zero.
- R2: In up mode (`count_mode`=0) with `run` high, the counter steps by one each cycle. On the edge where it is at or above the channel 0 shadow value, it goes to 0. With `run` low the counter holds its value.
- R3: In up/down mode (`count_mode`=1) the counter rises until it is at or above the channel 0 shadow value and then steps down. On reaching 0 it turns and steps up again. With a period of P the sequence repeats every 2P cycles.
- R4: A write (`wr_en` high) stores `wr_data` into the register of the channel numbered `wr_sel` on that clock edge. A `wr_sel` of `NUM_CH` or more selects no channel.
- R5: In load mode 00 a new register value enters the shadow latch on the same edge that stores it in the register.
- R6: In load mode 01 a new value waits, and moves to the shadow latch on the first later edge at which the counter reads 0.
- R7: In load mode 10 a waiting value moves at a counter of 0 in up mode. In up/down mode it moves at a counter of 0 or at a counter equal to the present shadow value.
- R8: In load mode 11 a waiting value moves on the edge at which the counter equals the present (old) shadow value.
- R9: The shadow latch changes only through a transfer. A second write before the trigger replaces the waiting value, so the latch receives only the newer one. A transfer copies the register as it stood before the edge.
- R10: Each compare-mode channel other than channel 0 drives a registered output. The output goes to 1 on the edge after the counter equals the channel 0 shadow value, and goes to 0 on the edge after the counter equals its own shadow value. When both match, the set wins. In up mode with duty D below period P, the output is high for the D+1 counter values 0..D. Channel 0's output is always 0.
- R11: With `chan_capture` set, `edge_sel` for the channel picks the capture event: 00 none, 01 rising, 10 falling, 11 either. On that edge the counter value from before the edge is stored in the channel register. A write on the same edge takes priority.
- R12: A captured value moves to the shadow latch under the channel's load mode, exactly as a written value does. A channel in capture mode holds its PWM output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter enable |
| count_mode | input | 1 | 0 up mode, 1 up/down mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | $clog2(NUM_CH) | Channel selected for the write |
| wr_data | input | 16 | Value written |
| chan_capture | input | NUM_CH | Per channel: 1 capture, 0 compare |
| load_mode | input | 2*NUM_CH | Per channel load-timing field, channel i at bits 2i+1:2i |
| edge_sel | input | 2*NUM_CH | Per channel capture edge field, channel i at bits 2i+1:2i |
| cap_in | input | NUM_CH | Capture inputs |
| count | output | 16 | Counter value |
| chan_reg | output | 16*NUM_CH | Channel registers, channel i at bits 16i+15:16i |
| chan_shadow | output | 16*NUM_CH | Shadow latches, channel i at bits 16i+15:16i |
| pwm_out | output | NUM_CH | PWM outputs, bit 0 always 0 |

## Verification
The counter, each channel register and each shadow latch show the result of a stimulus one clock edge after the inputs are presented. A PWM output reacts one edge after the counter shows the matching value, so it trails the counter by one cycle. The bench drives inputs on the falling edge. It then advances its own model of the requirements by exactly one rising edge, using the values that were visible before that edge, and compares every output at the next falling edge. The transfer triggers, the counter turns and the PWM set and clear points are therefore each checked in the very cycle in which they are due.

// File: rtl/dbt_pkg.sv
`timescale 1ns/1ps
package dbt_pkg;
    parameter int CNT_W = 16;

    typedef logic [CNT_W-1:0] tval_t;

    typedef enum logic {
        CM_UP     = 1'b0,
        CM_UPDOWN = 1'b1
    } count_mode_e;

    typedef enum logic [1:0] {
        LD_NOW         = 2'b00,
        LD_AT_ZERO     = 2'b01,
        LD_ZERO_OR_HIT = 2'b10,
        LD_AT_HIT      = 2'b11
    } load_mode_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        tval_t cmp;
        tval_t shadow;
        logic  pending;
    } chan_state_t;

    function automatic logic edge_hit(edge_sel_e sel, logic prev, logic cur);
        logic hit;
        case (sel)
            EDGE_RISE: hit = !prev && cur;
            EDGE_FALL: hit = prev && !cur;
            EDGE_ANY:  hit = prev != cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic load_trigger(load_mode_e m, count_mode_e cm,
                                          tval_t cnt, tval_t shadow);
        logic t;
        case (m)
            LD_NOW:         t = 1'b1;
            LD_AT_ZERO:     t = (cnt == '0);
            LD_ZERO_OR_HIT: t = (cnt == '0) || (cm == CM_UPDOWN && cnt == shadow);
            default:        t = (cnt == shadow);
        endcase
        return t;
    endfunction
endpackage

// File: rtl/dbt_counter.sv
`timescale 1ns/1ps
module dbt_counter
    import dbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  count_mode_e mode,
    input  tval_t       period,
    output tval_t       count
);
    tval_t cnt_q, cnt_d;
    logic  dir_up_q, dir_up_d;

    always_comb begin
        cnt_d    = cnt_q;
        dir_up_d = dir_up_q;
        if (run) begin
            if (mode == CM_UP) begin
                dir_up_d = 1'b1;
                cnt_d    = (cnt_q >= period) ? '0 : cnt_q + 1'b1;
            end else if (dir_up_q) begin
                if (cnt_q >= period) begin
                    dir_up_d = 1'b0;
                    cnt_d    = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == '0) begin
                    dir_up_d = 1'b1;
                    cnt_d    = (period == '0) ? '0 : tval_t'(1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            dir_up_q <= 1'b1;
        end else begin
            cnt_q    <= cnt_d;
            dir_up_q <= dir_up_d;
        end
    end

    assign count = cnt_q;

    p_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (run && mode == CM_UP && count >= period) |=> (count == '0));
    p_up_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && mode == CM_UP && count < period) |=> (count == $past(count) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));
    p_ud_turn_r3: assert property (@(posedge clk) disable iff (rst)
        (run && mode == CM_UPDOWN && count == period && period != '0)
        |=> (count == $past(period) - 1'b1));
endmodule

// File: rtl/dbt_channel.sv
`timescale 1ns/1ps
module dbt_channel
    import dbt_pkg::*;
#(
    parameter bit IS_PERIOD = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  tval_t       count,
    input  tval_t       period,
    input  count_mode_e cmode,
    input  logic        wr_hit,
    input  tval_t       wr_data,
    input  logic        capture_mode,
    input  load_mode_e  ld_mode,
    input  edge_sel_e   edge_sel,
    input  logic        cap_in,
    output tval_t       reg_q,
    output tval_t       shadow_q,
    output logic        pwm_q
);
    logic        cap_prev, cap_evt, new_valid, trig;
    tval_t       new_val;
    chan_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) cap_prev <= 1'b0;
        else     cap_prev <= cap_in;
    end

    assign cap_evt   = capture_mode && edge_hit(edge_sel, cap_prev, cap_in);
    assign new_valid = wr_hit || cap_evt;
    assign new_val   = wr_hit ? wr_data : count;
    assign trig      = load_trigger(ld_mode, cmode, count, st_q.shadow);

    always_comb begin
        st_d = st_q;
        if (new_valid) begin
            st_d.cmp = new_val;
            if (ld_mode == LD_NOW) begin
                st_d.shadow  = new_val;
                st_d.pending = 1'b0;
            end else begin
                if (st_q.pending && trig) st_d.shadow = st_q.cmp;
                st_d.pending = 1'b1;
            end
        end else if (st_q.pending && trig) begin
            st_d.shadow  = st_q.cmp;
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                            pwm_q <= 1'b0;
        else if (IS_PERIOD || capture_mode) pwm_q <= 1'b0;
        else if (count == period)           pwm_q <= 1'b1;
        else if (count == st_q.shadow)      pwm_q <= 1'b0;
    end

    assign reg_q    = st_q.cmp;
    assign shadow_q = st_q.shadow;

    p_now_load_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && ld_mode == LD_NOW) |=> (shadow_q == $past(wr_data)));
    p_shadow_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !cap_evt && !st_q.pending) |=> $stable(shadow_q));
    p_capture_r11: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && !wr_hit) |=> (reg_q == $past(count)));
    p_set_r10: assert property (@(posedge clk) disable iff (rst)
        (!IS_PERIOD && !capture_mode && count == period) |=> pwm_q);
    p_cap_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        capture_mode |=> !pwm_q);
endmodule

// File: rtl/dbuf_timer.sv
`timescale 1ns/1ps
module dbuf_timer
    import dbt_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    count_mode,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic [NUM_CH-1:0]       chan_capture,
    input  logic [2*NUM_CH-1:0]     load_mode,
    input  logic [2*NUM_CH-1:0]     edge_sel,
    input  logic [NUM_CH-1:0]       cap_in,
    output logic [CNT_W-1:0]        count,
    output logic [CNT_W*NUM_CH-1:0] chan_reg,
    output logic [CNT_W*NUM_CH-1:0] chan_shadow,
    output logic [NUM_CH-1:0]       pwm_out
);
    tval_t       cnt;
    tval_t       shadow_arr [NUM_CH];
    tval_t       reg_arr    [NUM_CH];
    count_mode_e cmode;

    assign cmode = count_mode_e'(count_mode);

    dbt_counter u_counter (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .mode   (cmode),
        .period (shadow_arr[0]),
        .count  (cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_sel == SEL_W'(g));

        dbt_channel #(.IS_PERIOD(g == 0)) u_ch (
            .clk          (clk),
            .rst          (rst),
            .count        (cnt),
            .period       (shadow_arr[0]),
            .cmode        (cmode),
            .wr_hit       (hit),
            .wr_data      (wr_data),
            .capture_mode (chan_capture[g]),
            .ld_mode      (load_mode_e'(load_mode[2*g +: 2])),
            .edge_sel     (edge_sel_e'(edge_sel[2*g +: 2])),
            .cap_in       (cap_in[g]),
            .reg_q        (reg_arr[g]),
            .shadow_q     (shadow_arr[g]),
            .pwm_q        (pwm_out[g])
        );

        assign chan_reg[CNT_W*g +: CNT_W]    = reg_arr[g];
        assign chan_shadow[CNT_W*g +: CNT_W] = shadow_arr[g];
    end

    assign count = cnt;

    p_ch0_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !pwm_out[0]);
endmodule

// File: tb/dbuf_timer_tb.sv
`timescale 1ns/1ps
module dbuf_timer_tb;
    localparam int NUM_CH = 3;
    localparam int SEL_W  = $clog2(NUM_CH);

    logic                 clk = 1'b0;
    logic                 rst, run, count_mode, wr_en;
    logic [SEL_W-1:0]     wr_sel;
    logic [15:0]          wr_data;
    logic [NUM_CH-1:0]    chan_capture, cap_in, pwm_out;
    logic [2*NUM_CH-1:0]  load_mode, edge_sel;
    logic [15:0]          count;
    logic [16*NUM_CH-1:0] chan_reg, chan_shadow;

    always #5 clk = ~clk;

    dbuf_timer #(.NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst(rst), .run(run), .count_mode(count_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .chan_capture(chan_capture), .load_mode(load_mode), .edge_sel(edge_sel),
        .cap_in(cap_in), .count(count), .chan_reg(chan_reg),
        .chan_shadow(chan_shadow), .pwm_out(pwm_out)
    );

    int n_vec = 0;
    int n_err = 0;
    string cur_req = "R5";

    logic [15:0] m_cnt;
    logic        m_dir;
    logic [15:0] m_reg [NUM_CH];
    logic [15:0] m_sh  [NUM_CH];
    logic        m_pend[NUM_CH];
    logic        m_pwm [NUM_CH];
    logic        m_prev[NUM_CH];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit trig(logic [1:0] lm, logic ud, logic [15:0] c, logic [15:0] s);
        case (lm)
            2'b00:   return 1'b1;
            2'b01:   return c == 16'd0;
            2'b10:   return ud ? (c == 16'd0 || c == s) : (c == 16'd0);
            default: return c == s;
        endcase
    endfunction

    task automatic model_edge();
        logic [15:0] p;
        p = m_sh[0];
        for (int i = 0; i < NUM_CH; i++) begin
            logic [1:0]  lm, es;
            logic        hit, evt, wh, tg;
            logic [15:0] nv;
            lm  = load_mode[2*i +: 2];
            es  = edge_sel[2*i +: 2];
            hit = (es == 2'b01 && !m_prev[i] && cap_in[i]) ||
                  (es == 2'b10 && m_prev[i] && !cap_in[i]) ||
                  (es == 2'b11 && m_prev[i] != cap_in[i]);
            evt = chan_capture[i] && hit;
            wh  = wr_en && (int'(wr_sel) == i);
            nv  = wh ? wr_data : m_cnt;
            tg  = trig(lm, count_mode, m_cnt, m_sh[i]);
            if (i == 0 || chan_capture[i]) m_pwm[i] = 1'b0;
            else if (m_cnt == p)           m_pwm[i] = 1'b1;
            else if (m_cnt == m_sh[i])     m_pwm[i] = 1'b0;
            if (wh || evt) begin
                if (lm == 2'b00) begin
                    m_sh[i]   = nv;
                    m_pend[i] = 1'b0;
                end else begin
                    if (m_pend[i] && tg) m_sh[i] = m_reg[i];
                    m_pend[i] = 1'b1;
                end
                m_reg[i] = nv;
            end else if (m_pend[i] && tg) begin
                m_sh[i]   = m_reg[i];
                m_pend[i] = 1'b0;
            end
            m_prev[i] = cap_in[i];
        end
        if (run) begin
            if (!count_mode) begin
                m_dir = 1'b1;
                m_cnt = (m_cnt >= p) ? 16'd0 : m_cnt + 16'd1;
            end else if (m_dir) begin
                if (m_cnt >= p) begin
                    m_dir = 1'b0;
                    m_cnt = (m_cnt == 16'd0) ? 16'd0 : m_cnt - 16'd1;
                end else m_cnt = m_cnt + 16'd1;
            end else begin
                if (m_cnt == 16'd0) begin
                    m_dir = 1'b1;
                    m_cnt = (p == 16'd0) ? 16'd0 : 16'd1;
                end else m_cnt = m_cnt - 16'd1;
            end
        end
    endtask

    task automatic compare();
        chk(count_mode ? "R3" : "R2", "count", {16'd0, count}, {16'd0, m_cnt});
        for (int i = 0; i < NUM_CH; i++) begin
            chk(chan_capture[i] ? "R11" : "R4", $sformatf("reg%0d", i),
                {16'd0, chan_reg[16*i +: 16]}, {16'd0, m_reg[i]});
            chk(cur_req, $sformatf("shadow%0d", i),
                {16'd0, chan_shadow[16*i +: 16]}, {16'd0, m_sh[i]});
            chk(chan_capture[i] ? "R12" : "R10", $sformatf("pwm%0d", i),
                {31'd0, pwm_out[i]}, {31'd0, m_pwm[i]});
        end
    endtask

    task automatic step();
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic run_n(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(int ch, logic [15:0] v);
        wr_en   = 1'b1;
        wr_sel  = SEL_W'(ch);
        wr_data = v;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic set_ld(int ch, logic [1:0] m);
        load_mode[2*ch +: 2] = m;
    endtask

    task automatic pulse(int ch);
        cap_in[ch] = 1'b1;
        run_n(3);
        cap_in[ch] = 1'b0;
        run_n(3);
    endtask

    initial begin
        rst = 1'b1; run = 1'b0; count_mode = 1'b0; wr_en = 1'b0;
        wr_sel = '0; wr_data = '0; chan_capture = '0; cap_in = '0;
        load_mode = '0; edge_sel = '0;
        m_cnt = '0; m_dir = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            m_reg[i] = '0; m_sh[i] = '0; m_pend[i] = 1'b0;
            m_pwm[i] = 1'b0; m_prev[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "count", {16'd0, count}, 32'd0);
        chk("R1", "regs", {16'd0, chan_reg[15:0] | chan_reg[31:16] | chan_reg[47:32]}, 32'd0);
        chk("R1", "shadows", {16'd0, chan_shadow[15:0] | chan_shadow[31:16] | chan_shadow[47:32]}, 32'd0);
        chk("R1", "pwm", {29'd0, pwm_out}, 32'd0);
        rst = 1'b0;

        // R4 and R5: immediate loads, plus an out-of-range select
        cur_req = "R5";
        wr(0, 16'd9);
        wr(1, 16'd4);
        wr(2, 16'd0);
        wr(3, 16'hBEEF);

        // R2 and R10: up mode, near-exhaustive duty sweep on channel 2
        run = 1'b1;
        run_n(40);
        for (int d = 0; d <= 11; d++) begin
            wr(2, 16'(d));
            run_n(22);
        end
        run = 1'b0;
        run_n(3);
        run = 1'b1;

        // R6: load at zero
        cur_req = "R6";
        set_ld(1, 2'b01);
        run_n(3);
        wr(1, 16'd7);
        run_n(25);

        // R8: load when counter meets the old shadow
        cur_req = "R8";
        set_ld(1, 2'b11);
        run_n(2);
        wr(1, 16'd5);
        run_n(20);

        // R9: second write replaces the waiting one
        cur_req = "R9";
        run_n(3);
        wr(1, 16'd2);
        wr(1, 16'd3);
        run_n(20);

        // R7: mode 10 in up mode, then in up/down mode
        cur_req = "R7";
        set_ld(1, 2'b10);
        run_n(4);
        wr(1, 16'd6);
        run_n(20);
        count_mode = 1'b1;
        run_n(30);
        wr(1, 16'd8);
        run_n(30);
        wr(1, 16'd2);
        run_n(30);

        // R3 and R6: period retuned at zero in up/down mode
        cur_req = "R6";
        set_ld(0, 2'b01);
        run_n(3);
        wr(0, 16'd5);
        run_n(30);
        count_mode = 1'b0;
        run_n(12);

        // R11: capture edges on channel 2
        cur_req = "R11";
        chan_capture[2] = 1'b1;
        set_ld(2, 2'b00);
        edge_sel[5:4] = 2'b01; run_n(2); pulse(2);
        edge_sel[5:4] = 2'b10; run_n(2); pulse(2);
        edge_sel[5:4] = 2'b11; run_n(2); pulse(2);
        edge_sel[5:4] = 2'b00; run_n(2); pulse(2);

        // R12: captured value waits for the zero trigger
        cur_req = "R12";
        set_ld(2, 2'b01);
        edge_sel[5:4] = 2'b01;
        run_n(2);
        pulse(2);
        run_n(12);
        chan_capture[2] = 1'b0;
        run_n(15);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule